// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single read or write requests from a processor core into bus cycles on a set of 8-bit ports. It drives an active-low address strobe, an active-low data strobe and a read/write line. A request is accepted only while the controller is idle. Once accepted, the request runs through a fixed five-clock sequence: an address phase, a release of the address strobe, two clocks with the data strobe low, and a final clock in which the data strobe is high again. A one-clock done pulse then hands the result back to the core. For a read, the result is the byte captured when the data strobe rises.

Two port arrangements are supported, and the mode input is sampled when a request is accepted. In multiplexed mode the data port carries the low address byte during the address phase and then the data. In demultiplexed mode a separate low-address port holds the low byte for the whole cycle, and the data port carries data only. In both modes a third port drives the upper address byte for the whole cycle. Each output port has its own enable, so the pads around the block can tristate it. A port that is not enabled drives zero.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset and whenever idle: as_n=1, ds_n=1, rw=1, req_ready=1, rsp_done=0, all three output enables 0, and ad_out, alo_out and ahi_out equal 0.
- R2: A request accepted at clock edge k gives as_n=0 for exactly the cycle after edge k, then as_n=1 with ds_n=1 for one cycle, then ds_n=0 for two cycles, then ds_n=1 for one cycle, after which the controller is idle again.
- R3: rw is 1 for a read (req_write=0) and 0 for a write (req_write=1), held from the as_n-low cycle through the last cycle of the sequence.
- R4: In multiplexed mode (demux_mode=0), ad_out equals address bits [7:0] with ad_oe=1 during the as_n-low cycle and the following cycle, and alo_oe stays 0.
- R5: In demultiplexed mode (demux_mode=1), alo_out equals address bits [7:0] with alo_oe=1 for all five cycles, and ad_oe is 0 during the two address cycles.
- R6: In both modes, ahi_out equals address bits [15:8] with ahi_oe=1 for all five cycles.
- R7: On a write, ad_out equals the write data with ad_oe=1 during both ds_n-low cycles and the one cycle after ds_n rises.
- R8: On a read, ad_oe is 0 from the first ds_n-low cycle to the end of the sequence. The value on ad_in in the last ds_n-low cycle (the clock edge where ds_n rises) is the one captured.
- R9: rsp_done is a one-cycle pulse in the final cycle of the sequence, and rsp_rdata carries the captured read byte there. rsp_rdata holds its value afterwards and does not change on writes.
- R10: While a cycle is in progress, req_ready is 0. Any request, address, data, direction or mode change presented then has no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bus address |
| req_wdata | input | 8 | Write data |
| demux_mode | input | 1 | 0 = multiplexed, 1 = demultiplexed; sampled on accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | High = read, low = write |
| ad_out | output | 8 | Data port output value |
| ad_oe | output | 1 | Data port output enable |
| ad_in | input | 8 | Data port input value |
| alo_out | output | 8 | Low-address port output value |
| alo_oe | output | 1 | Low-address port output enable |
| ahi_out | output | 8 | Upper-address port output value |
| ahi_oe | output | 1 | Upper-address port output enable |

## Verification
The bench sweeps both modes and both directions over a spread of addresses and data. It checks every pin in every clock of each cycle. During a read it drives a different decoy byte on the data port in each clock, so a controller that captures one edge early or late returns a decoy instead of the expected byte. A design that keeps the data port enabled into a read's data phase, or releases a write's data before the strobe rises, shows a wrong enable in a specific clock. While each cycle runs, the bench holds a new request and flips the mode, address and direction. A controller that accepts work while busy, or samples the mode late, then puts the wrong bytes on the address ports.

// File: rtl/xbus_pkg.sv
// Shared definitions for the external bus controller.
// Assumes one system clock per bus phase.
package xbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,  // no cycle in progress
        PH_ADDR = 3'd1,  // address strobe low, address on pins
        PH_ALAT = 3'd2,  // address strobe released (address latched outside)
        PH_DSTB = 3'd3,  // data strobe asserted
        PH_DHLD = 3'd4,  // data strobe held
        PH_DEND = 3'd5   // data strobe released, completion
    } phase_t;
endpackage

// File: rtl/xbus_seq.sv
// Phase sequencer: accepts one request while idle and steps through the
// fixed five-phase bus cycle. Latches address, data, direction and mode
// at acceptance so that later input changes cannot affect the cycle.
// Assumes synchronous active-low reset.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          demux_mode,
    output logic          req_ready,
    output phase_t        phase,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_wdata,
    output logic          lat_write,
    output logic          lat_demux
);
    phase_t phase_nxt;
    logic   accept;

    // Purpose: ready only while no cycle is in progress.
    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_ready && req_valid;

    // Purpose: fixed phase order, one clock per phase.
    always_comb begin
        case (phase)
            PH_IDLE: phase_nxt = req_valid ? PH_ADDR : PH_IDLE;
            PH_ADDR: phase_nxt = PH_ALAT;
            PH_ALAT: phase_nxt = PH_DSTB;
            PH_DSTB: phase_nxt = PH_DHLD;
            PH_DHLD: phase_nxt = PH_DEND;
            PH_DEND: phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Purpose: phase register and request latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_demux <= 1'b0;
        end else begin
            phase <= phase_nxt;
            if (accept) begin
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
                lat_write <= req_write;
                lat_demux <= demux_mode;
            end
        end
    end

    // R10: a running cycle never picks up new request fields.
    a_r10_latch_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(lat_addr) && $stable(lat_wdata)
                                && $stable(lat_write) && $stable(lat_demux)));

    // R2: once started, a cycle always returns to idle through the end phase.
    a_r2_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEND) |=> req_ready);
endmodule

// File: rtl/xbus_drive.sv
// Pin driver: decodes the current phase and latched request into strobe,
// direction, port values and port output enables. Ports not enabled drive
// zero. Purely combinational; clk and rst_n serve the local assertions.
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic [AW-1:0] lat_addr,
    input  logic [DW-1:0] lat_wdata,
    input  logic          lat_write,
    input  logic          lat_demux,
    output logic          as_n,
    output logic          ds_n,
    output logic          rw,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] alo_out,
    output logic          alo_oe,
    output logic [DW-1:0] ahi_out,
    output logic          ahi_oe
);
    logic active, addr_ph, data_ph, strobe_ph;
    logic mux_addr_drv, wr_data_drv;

    // Purpose: phase group decode.
    always_comb begin
        active    = (phase != PH_IDLE);
        addr_ph   = (phase == PH_ADDR) || (phase == PH_ALAT);
        strobe_ph = (phase == PH_DSTB) || (phase == PH_DHLD);
        data_ph   = strobe_ph || (phase == PH_DEND);
    end

    // Purpose: strobes and direction line.
    always_comb begin
        as_n = !(phase == PH_ADDR);
        ds_n = !strobe_ph;
        rw   = !(active && lat_write);
    end

    // Purpose: address ports, upper byte always, lower byte in demux mode.
    always_comb begin
        ahi_oe  = active;
        ahi_out = active ? lat_addr[AW-1:DW] : '0;
        alo_oe  = active && lat_demux;
        alo_out = (active && lat_demux) ? lat_addr[DW-1:0] : '0;
    end

    // Purpose: data port sharing between mux address and write data.
    always_comb begin
        mux_addr_drv = addr_ph && !lat_demux;
        wr_data_drv  = data_ph && lat_write;
        ad_oe        = mux_addr_drv || wr_data_drv;
        if (mux_addr_drv)
            ad_out = lat_addr[DW-1:0];
        else if (wr_data_drv)
            ad_out = lat_wdata;
        else
            ad_out = '0;
    end

    // R8: a read never drives the data port while the data strobe is low.
    a_r8_read_port_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw) |-> !ad_oe);

    // R7: write data stays driven through the cycle after ds_n rises.
    a_r7_write_held_past_ds: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ds_n) && !rw) |-> ad_oe);

    // R5: in demux mode the data port is quiet during the address strobe.
    a_r5_demux_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (alo_oe && !as_n) |-> !ad_oe);

    // R6: upper address byte does not move inside a cycle.
    a_r6_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ahi_oe && $past(ahi_oe)) |-> $stable(ahi_out));

    // R2: the two strobes are never low together.
    a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n && !ds_n));
endmodule

// File: rtl/xbus_capture.sv
// Read capture: registers the data port on the clock edge where the data
// strobe rises during a read, and flags completion in the final phase.
// Writes leave the captured byte untouched.
module xbus_capture
    import xbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic          lat_write,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done
);
    logic cap_en;

    // Purpose: capture at the edge that ends the strobe-hold phase.
    assign cap_en = (phase == PH_DHLD) && !lat_write;

    // Purpose: read data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (cap_en)
            rsp_rdata <= ad_in;
    end

    // Purpose: completion flag in the release phase.
    assign rsp_done = (phase == PH_DEND);

    // R9: done lasts exactly one clock.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9: read data only moves after a read's hold phase.
    a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |=> ($stable(rsp_rdata) || rsp_done));
endmodule

// File: rtl/xbus_ctrl.sv
// External bus controller top: joins the sequencer, pin driver and read
// capture. Assumes pads outside apply the output enables and feed the
// data port back on ad_in; port widths follow DW, address width is 2*DW.
module xbus_ctrl #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [2*DW-1:0] req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            demux_mode,
    output logic            rsp_done,
    output logic [DW-1:0]   rsp_rdata,
    output logic            as_n,
    output logic            ds_n,
    output logic            rw,
    output logic [DW-1:0]   ad_out,
    output logic            ad_oe,
    input  logic [DW-1:0]   ad_in,
    output logic [DW-1:0]   alo_out,
    output logic            alo_oe,
    output logic [DW-1:0]   ahi_out,
    output logic            ahi_oe
);
    import xbus_pkg::*;
    localparam int AW = 2 * DW;

    phase_t        phase;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic          lat_write;
    logic          lat_demux;

    xbus_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .demux_mode(demux_mode),
        .req_ready(req_ready), .phase(phase), .lat_addr(lat_addr),
        .lat_wdata(lat_wdata), .lat_write(lat_write), .lat_demux(lat_demux)
    );

    xbus_drive #(.DW(DW), .AW(AW)) u_drive (
        .clk(clk), .rst_n(rst_n), .phase(phase), .lat_addr(lat_addr),
        .lat_wdata(lat_wdata), .lat_write(lat_write), .lat_demux(lat_demux),
        .as_n(as_n), .ds_n(ds_n), .rw(rw), .ad_out(ad_out), .ad_oe(ad_oe),
        .alo_out(alo_out), .alo_oe(alo_oe), .ahi_out(ahi_out), .ahi_oe(ahi_oe)
    );

    xbus_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .phase(phase), .lat_write(lat_write),
        .ad_in(ad_in), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
    );

    // R1: while ready, the pins sit in their idle levels.
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (as_n && ds_n && rw && !rsp_done && !ad_oe && !alo_oe && !ahi_oe));

    // R2: the data strobe falls one clock after the address strobe rises.
    a_r2_ds_after_as: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> ($past(as_n) && !$past(as_n, 2)));
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        demux_mode = 1'b0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        as_n, ds_n, rw, ad_oe, alo_oe, ahi_oe;
    logic [7:0]  ad_out, alo_out, ahi_out;
    logic [7:0]  ad_in = '0;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic [7:0] prev_rd = '0;

    xbus_ctrl #(.DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .demux_mode(demux_mode), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .as_n(as_n), .ds_n(ds_n), .rw(rw), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .alo_out(alo_out), .alo_oe(alo_oe),
        .ahi_out(ahi_out), .ahi_oe(ahi_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string when);
        check({"R1 ready ", when}, req_ready, 1);
        check({"R1 as_n ", when}, as_n, 1);
        check({"R1 ds_n ", when}, ds_n, 1);
        check({"R1 rw ", when}, rw, 1);
        check({"R1 done ", when}, rsp_done, 0);
        check({"R1 oes ", when}, {ad_oe, alo_oe, ahi_oe}, 0);
        check({"R1 port values ", when}, {ad_out, alo_out, ahi_out}, 0);
    endtask

    // Address-side checks shared by all five cycles of a transaction.
    task automatic check_addr(input bit md, input bit wr, input logic [15:0] a);
        check("R3 rw", rw, !wr);
        check("R6 ahi_out", ahi_out, a[15:8]);
        check("R6 ahi_oe", ahi_oe, 1);
        check("R10 busy ready", req_ready, 0);
        if (md) begin
            check("R5 alo_oe", alo_oe, 1);
            check("R5 alo_out", alo_out, a[7:0]);
        end else begin
            check("R4 alo_oe", alo_oe, 0);
        end
    endtask

    task automatic check_data(input bit wr, input logic [7:0] wd);
        if (wr) begin
            check("R7 ad_oe", ad_oe, 1);
            check("R7 ad_out", ad_out, wd);
        end else begin
            check("R8 ad_oe", ad_oe, 0);
        end
    endtask

    task automatic do_txn(input bit md, input bit wr, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] rb);
        @(negedge clk);
        check_idle("before request");
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = a;
        req_wdata  = wd;
        demux_mode = md;
        ad_in      = 8'h00;
        // address strobe low
        @(negedge clk);
        req_write  = !wr;
        req_addr   = ~a;
        req_wdata  = ~wd;
        demux_mode = !md;
        check("R2 as_n low", as_n, 0);
        check("R2 ds_n high in addr", ds_n, 1);
        check_addr(md, wr, a);
        if (md) check("R5 ad_oe in addr", ad_oe, 0);
        else begin
            check("R4 ad_oe in addr", ad_oe, 1);
            check("R4 ad_out in addr", ad_out, a[7:0]);
        end
        // address strobe released
        @(negedge clk);
        ad_in = rb ^ 8'hFF;
        check("R2 as_n released", as_n, 1);
        check("R2 ds_n high in latch", ds_n, 1);
        check_addr(md, wr, a);
        if (md) check("R5 ad_oe in latch", ad_oe, 0);
        else begin
            check("R4 ad_oe in latch", ad_oe, 1);
            check("R4 ad_out in latch", ad_out, a[7:0]);
        end
        // data strobe first cycle
        @(negedge clk);
        ad_in = rb ^ 8'h5A;
        check("R2 ds_n low 1", ds_n, 0);
        check("R2 as_n high in data", as_n, 1);
        check_addr(md, wr, a);
        check_data(wr, wd);
        // data strobe second cycle
        @(negedge clk);
        ad_in = rb;
        check("R2 ds_n low 2", ds_n, 0);
        check_addr(md, wr, a);
        check_data(wr, wd);
        // data strobe released, completion
        @(negedge clk);
        ad_in     = ~rb;
        req_valid = 1'b0;
        if (!wr) prev_rd = rb;
        check("R2 ds_n released", ds_n, 1);
        check("R9 done pulse", rsp_done, 1);
        check(wr ? "R9 rdata unchanged by write" : "R8 captured byte", rsp_rdata, prev_rd);
        check_addr(md, wr, a);
        check_data(wr, wd);
        // back to idle
        @(negedge clk);
        check_idle("after cycle");
        check("R9 rdata held", rsp_rdata, prev_rd);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");
        check("R1 rdata reset", rsp_rdata, 0);
        for (int md = 0; md < 2; md++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int i = 0; i < 16; i++) begin
                    logic [15:0] a;
                    logic [7:0]  wd, rb;
                    a  = 16'(i * 16'h1357 + md * 16'h8001 + wr * 16'h0420);
                    if (i == 15) a = md ? 16'hFFFF : 16'h0000;
                    wd = 8'(i * 8'h1D + 8'h05);
                    rb = 8'(~wd ^ 8'(i));
                    do_txn(md[0], wr[0], a, wd, rb);
                end
            end
        end
        // alternating directions and modes back to back
        for (int k = 0; k < 8; k++) begin
            do_txn(k[1], k[0], 16'(16'hA5C3 ^ (k * 16'h0911)), 8'(8'h3C + k), 8'(8'hC0 | k));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule